// File: doc/BRIEF.md
# Transactional Conflict Resolution Unit

This block settles what happens when a memory request from one core collides with a transaction that is running on another core. Each query describes one request. It gives the access kind, whether the requester runs inside a transaction, the start timestamps and core indices of both parties, and whether the holder's read set and write set contain the block. Conflicts are detected eagerly, so the verdict is reached when the request is made and not at commit time.

A two-bit policy input selects one of four resolution rules: always against the requester, age ordering, age ordering that also lets older requesters evict read-only holders, and an unconditional trap to a software contention manager. One cycle after a query, the block raises a response strobe. When there is a conflict, exactly one of four verdict strobes is raised with it: nack the requester, abort the requester, abort the holder, or trap.

Top module: `txn_conflict_arbiter`

## Requirements
- R1: A conflict exists when a write request finds the block in the holder's read set or write set, or when a read request finds it in the holder's write set. A read that finds the block only in the read set, or any request that finds it in neither set, is answered with `resp_valid` high, `is_conflict` low and all four verdict strobes low.
- R2: `resp_valid` is high in the cycle after each cycle in which `query_valid` is sampled high, and low otherwise.
- R3: Every response with `is_conflict` high carries exactly one of `nack_req`, `abort_req`, `abort_hold` and `trap_sw`.
- R4: With policy 0 (base), a conflict from a transactional requester aborts the requester.
- R5: With policy 1 (age order), a transactional requester that is younger than the holder is aborted. An older one is nacked.
- R6: With policy 2 (hybrid), an older transactional requester aborts the holder when the holder has the block in its read set and not in its write set. It is nacked when the holder's write set contains the block. A younger transactional requester is aborted.
- R7: With policy 3 (trap), every conflict raises `trap_sw`, whether or not the requester is transactional.
- R8: The requester is older when (holder_ts - req_ts) modulo 2^TS_W is nonzero and its top bit is clear. This holds across counter wrap. When the timestamps are equal, the side with the lower core index is older.
- R9: A non-transactional requester never gets `abort_req`. Under policies 0 and 1 it is nacked. Under policy 2 it counts as older, so a read-only holder is aborted and any other holder causes a nack.
- R10: While reset is asserted and after its release, before any query, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| query_valid | input | 1 | A query is presented this cycle |
| req_is_write | input | 1 | Request is a store (1) or a load (0) |
| req_is_txn | input | 1 | Requester is inside a transaction |
| req_ts | input | TS_W | Requester transaction start timestamp |
| req_core | input | CORE_W | Requester core index |
| hold_ts | input | TS_W | Holder transaction start timestamp |
| hold_core | input | CORE_W | Holder core index |
| hold_in_rd | input | 1 | Block is in the holder's read set |
| hold_in_wr | input | 1 | Block is in the holder's write set |
| policy | input | 2 | 0 base, 1 age order, 2 hybrid, 3 trap |
| resp_valid | output | 1 | Verdict for the previous cycle's query |
| is_conflict | output | 1 | The answered query was a conflict |
| nack_req | output | 1 | Requester is told to retry |
| abort_req | output | 1 | Requester transaction aborts |
| abort_hold | output | 1 | Holder transaction aborts |
| trap_sw | output | 1 | Conflict is handed to the software contention manager |

## Verification
All outputs come from a single register stage, so every verdict, the conflict flag and the response strobe are due exactly one clock edge after the query is sampled. Nothing else delays them. The bench applies a query at a falling edge and reads the outputs at the next falling edge, which falls after the one capturing edge. It then drops the query and confirms that `resp_valid` falls a cycle later. The reset checks read the outputs at falling edges while reset is asserted and again after release with no query pending.

// File: rtl/txn_arb_pkg.sv
package txn_arb_pkg;

  typedef enum logic [1:0] {
    POL_BASE   = 2'd0,
    POL_STAMP  = 2'd1,
    POL_HYBRID = 2'd2,
    POL_CYCLE  = 2'd3
  } policy_e;

  typedef struct packed {
    logic nack;
    logic abort_req;
    logic abort_hold;
    logic trap;
  } verdict_t;

  localparam verdict_t VERDICT_NONE = '{nack: 1'b0, abort_req: 1'b0, abort_hold: 1'b0, trap: 1'b0};

  // Store collides with any set membership; load only with the write set.
  function automatic logic access_collides(input logic is_wr, input logic in_rd, input logic in_wr);
    return in_wr | (is_wr & in_rd);
  endfunction

  // Wrap-safe age test: the requester started earlier when holder - requester
  // is a small positive distance, that is nonzero with a clear top bit.
  function automatic logic stamp_earlier(input logic [63:0] distance, input int unsigned width);
    logic top;
    logic nonzero;
    top     = distance[width-1];
    nonzero = (distance != 64'd0);
    return nonzero & ~top;
  endfunction

endpackage

// File: rtl/txn_conflict_detect.sv
module txn_conflict_detect
  import txn_arb_pkg::*;
(
  input  logic is_wr,
  input  logic in_rd,
  input  logic in_wr,
  output logic collide,
  output logic holder_rd_only
);
  always_comb begin
    collide        = access_collides(is_wr, in_rd, in_wr);
    holder_rd_only = in_rd & ~in_wr;
  end
endmodule

// File: rtl/txn_age_compare.sv
module txn_age_compare
  import txn_arb_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int CORE_W = 4
) (
  input  logic [TS_W-1:0]   req_ts,
  input  logic [TS_W-1:0]   hold_ts,
  input  logic [CORE_W-1:0] req_core,
  input  logic [CORE_W-1:0] hold_core,
  output logic              ts_tie,
  output logic              req_older
);
  localparam int PAD_W = 64 - TS_W;

  logic [TS_W-1:0] distance;
  logic            stamp_win;
  logic            core_win;

  always_comb begin
    distance  = hold_ts - req_ts;
    ts_tie    = (distance == '0);
    stamp_win = stamp_earlier({{PAD_W{1'b0}}, distance}, TS_W);
    core_win  = (req_core < hold_core);
    req_older = ts_tie ? core_win : stamp_win;
  end
endmodule

// File: rtl/txn_policy_decide.sv
module txn_policy_decide
  import txn_arb_pkg::*;
(
  input  policy_e  policy,
  input  logic     collide,
  input  logic     req_is_txn,
  input  logic     req_older,
  input  logic     holder_rd_only,
  output verdict_t verdict
);
  // A non-transactional requester has no timestamp; it is treated as older.
  logic eff_older;
  logic evict_holder;

  always_comb begin
    eff_older    = ~req_is_txn | req_older;
    evict_holder = eff_older & holder_rd_only;
    verdict      = VERDICT_NONE;
    if (collide) begin
      unique case (policy)
        POL_BASE: begin
          if (req_is_txn) verdict.abort_req = 1'b1;
          else            verdict.nack      = 1'b1;
        end
        POL_STAMP: begin
          if (eff_older)  verdict.nack      = 1'b1;
          else            verdict.abort_req = 1'b1;
        end
        POL_HYBRID: begin
          if (evict_holder)   verdict.abort_hold = 1'b1;
          else if (eff_older) verdict.nack       = 1'b1;
          else                verdict.abort_req  = 1'b1;
        end
        default: verdict.trap = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/txn_conflict_arbiter.sv
module txn_conflict_arbiter
  import txn_arb_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              query_valid,
  input  logic              req_is_write,
  input  logic              req_is_txn,
  input  logic [TS_W-1:0]   req_ts,
  input  logic [CORE_W-1:0] req_core,
  input  logic [TS_W-1:0]   hold_ts,
  input  logic [CORE_W-1:0] hold_core,
  input  logic              hold_in_rd,
  input  logic              hold_in_wr,
  input  logic [1:0]        policy,
  output logic              resp_valid,
  output logic              is_conflict,
  output logic              nack_req,
  output logic              abort_req,
  output logic              abort_hold,
  output logic              trap_sw
);
  // Named internal events
  logic     ev_collide;
  logic     ev_rd_only;
  logic     ev_tie;
  logic     ev_req_older;
  verdict_t ev_verdict;
  verdict_t verdict_q;

  txn_conflict_detect u_detect (
    .is_wr          (req_is_write),
    .in_rd          (hold_in_rd),
    .in_wr          (hold_in_wr),
    .collide        (ev_collide),
    .holder_rd_only (ev_rd_only)
  );

  txn_age_compare #(.TS_W(TS_W), .CORE_W(CORE_W)) u_age (
    .req_ts    (req_ts),
    .hold_ts   (hold_ts),
    .req_core  (req_core),
    .hold_core (hold_core),
    .ts_tie    (ev_tie),
    .req_older (ev_req_older)
  );

  txn_policy_decide u_decide (
    .policy         (policy_e'(policy)),
    .collide        (ev_collide),
    .req_is_txn     (req_is_txn),
    .req_older      (ev_req_older),
    .holder_rd_only (ev_rd_only),
    .verdict        (ev_verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      is_conflict <= 1'b0;
      verdict_q   <= VERDICT_NONE;
    end else begin
      resp_valid  <= query_valid;
      is_conflict <= query_valid & ev_collide;
      verdict_q   <= query_valid ? ev_verdict : VERDICT_NONE;
    end
  end

  assign nack_req   = verdict_q.nack;
  assign abort_req  = verdict_q.abort_req;
  assign abort_hold = verdict_q.abort_hold;
  assign trap_sw    = verdict_q.trap;

  // R2: response follows each query by exactly one cycle
  a_r2_resp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid |=> resp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !query_valid |=> !resp_valid);

  // R3: one verdict per conflict, none otherwise
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    is_conflict |-> $onehot({nack_req, abort_req, abort_hold, trap_sw}));
  a_r1_quiet_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    !is_conflict |-> ({nack_req, abort_req, abort_hold, trap_sw} == 4'b0));

  // R1: a load hitting only the read set is not a conflict
  a_r1_read_share: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && !req_is_write && !hold_in_wr) |=> !is_conflict);

  // R7: a trap only comes from the trap policy
  a_r7_trap_policy: assert property (@(posedge clk) disable iff (!rst_n)
    trap_sw |-> $past(policy) == 2'd3);

  // R9: a non-transactional requester is never aborted
  a_r9_nontxn_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && !req_is_txn) |=> !abort_req);

  // R4: base policy never aborts or nacks in favour of a transactional requester
  a_r4_base_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && req_is_txn && policy == 2'd0 && ev_collide) |=> abort_req);
endmodule

// File: tb/sim_txn_conflict_arbiter.sv
module sim_txn_conflict_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int TS_W   = 8;
  localparam int CORE_W = 2;
  localparam int VW     = 31;
  localparam int NVEC   = 19;

  // {policy[30:29], wr[28], txn[27], in_rd[26], in_wr[25], req_ts[24:17],
  //  hold_ts[16:9], req_core[8:7], hold_core[6:5], conflict[4],
  //  expect {nack, abort_req, abort_hold, trap}[3:0]}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {2'd0,1'b1,1'b1,1'b1,1'b0,8'h10,8'h20,2'd0,2'd1,1'b1,4'b0100}, // R4 store vs read set
    {2'd0,1'b0,1'b1,1'b0,1'b1,8'h10,8'h20,2'd0,2'd1,1'b1,4'b0100}, // R4 load vs write set
    {2'd0,1'b0,1'b1,1'b1,1'b0,8'h10,8'h20,2'd0,2'd1,1'b0,4'b0000}, // R1 load vs read set
    {2'd0,1'b1,1'b0,1'b1,1'b0,8'h10,8'h20,2'd0,2'd1,1'b1,4'b1000}, // R9 base non-txn
    {2'd1,1'b1,1'b1,1'b1,1'b0,8'h20,8'h10,2'd0,2'd1,1'b1,4'b0100}, // R5 younger
    {2'd1,1'b1,1'b1,1'b1,1'b0,8'h10,8'h20,2'd0,2'd1,1'b1,4'b1000}, // R5 older
    {2'd1,1'b1,1'b1,1'b0,1'b1,8'hF8,8'h04,2'd0,2'd1,1'b1,4'b1000}, // R8 wrap older
    {2'd1,1'b1,1'b1,1'b0,1'b1,8'h04,8'hF8,2'd0,2'd1,1'b1,4'b0100}, // R8 wrap younger
    {2'd1,1'b1,1'b1,1'b0,1'b1,8'h33,8'h33,2'd1,2'd2,1'b1,4'b1000}, // R8 tie low core wins
    {2'd1,1'b1,1'b1,1'b0,1'b1,8'h33,8'h33,2'd2,2'd1,1'b1,4'b0100}, // R8 tie high core loses
    {2'd2,1'b1,1'b1,1'b1,1'b0,8'h10,8'h20,2'd0,2'd1,1'b1,4'b0010}, // R6 evict reader
    {2'd2,1'b1,1'b1,1'b1,1'b1,8'h10,8'h20,2'd0,2'd1,1'b1,4'b1000}, // R6 writer holder
    {2'd2,1'b1,1'b1,1'b1,1'b0,8'h20,8'h10,2'd0,2'd1,1'b1,4'b0100}, // R6 younger
    {2'd2,1'b1,1'b0,1'b1,1'b0,8'h20,8'h10,2'd0,2'd1,1'b1,4'b0010}, // R9 hybrid non-txn
    {2'd2,1'b0,1'b0,1'b0,1'b1,8'h20,8'h10,2'd0,2'd1,1'b1,4'b1000}, // R9 hybrid non-txn nack
    {2'd3,1'b1,1'b1,1'b0,1'b1,8'h10,8'h20,2'd0,2'd1,1'b1,4'b0001}, // R7 txn trap
    {2'd3,1'b0,1'b0,1'b0,1'b1,8'h10,8'h20,2'd0,2'd1,1'b1,4'b0001}, // R7 non-txn trap
    {2'd3,1'b0,1'b1,1'b1,1'b0,8'h10,8'h20,2'd0,2'd1,1'b0,4'b0000}, // R1 trap mode, no conflict
    {2'd1,1'b1,1'b1,1'b0,1'b0,8'h10,8'h20,2'd0,2'd1,1'b0,4'b0000}  // R1 no set hit
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              query_valid = 1'b0;
  logic              req_is_write = 1'b0;
  logic              req_is_txn = 1'b0;
  logic [TS_W-1:0]   req_ts = '0;
  logic [CORE_W-1:0] req_core = '0;
  logic [TS_W-1:0]   hold_ts = '0;
  logic [CORE_W-1:0] hold_core = '0;
  logic              hold_in_rd = 1'b0;
  logic              hold_in_wr = 1'b0;
  logic [1:0]        policy = 2'd0;
  logic              resp_valid, is_conflict, nack_req, abort_req, abort_hold, trap_sw;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_conflict_arbiter #(.TS_W(TS_W), .CORE_W(CORE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .query_valid(query_valid),
    .req_is_write(req_is_write), .req_is_txn(req_is_txn),
    .req_ts(req_ts), .req_core(req_core), .hold_ts(hold_ts), .hold_core(hold_core),
    .hold_in_rd(hold_in_rd), .hold_in_wr(hold_in_wr), .policy(policy),
    .resp_valid(resp_valid), .is_conflict(is_conflict), .nack_req(nack_req),
    .abort_req(abort_req), .abort_hold(abort_hold), .trap_sw(trap_sw)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: {valid,conflict,nack,abort_req,abort_hold,trap} got %b expected %b",
               req, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {resp_valid, is_conflict, nack_req, abort_req, abort_hold, trap_sw};
  endfunction

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: run did not end, got hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    query_valid = 1'b1;
    req_is_write = 1'b1;
    hold_in_wr = 1'b1;
    @(negedge clk);
    check("R10 in reset", outs(), 6'b000000);
    query_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", outs(), 6'b000000);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      policy       = v[30:29];
      req_is_write = v[28];
      req_is_txn   = v[27];
      hold_in_rd   = v[26];
      hold_in_wr   = v[25];
      req_ts       = v[24:17];
      hold_ts      = v[16:9];
      req_core     = v[8:7];
      hold_core    = v[6:5];
      query_valid  = 1'b1;
      @(negedge clk);
      check($sformatf("R1-vector %0d (R3 R4 R5 R6 R7 R8 R9)", i), outs(), {1'b1, v[4], v[3:0]});
      query_valid = 1'b0;
    end

    // R2: no query, no response
    @(negedge clk);
    check("R2 idle", outs(), 6'b000000);

    // R2: back-to-back queries each answered next cycle
    policy = 2'd3; req_is_write = 1'b1; req_is_txn = 1'b1; hold_in_rd = 1'b0; hold_in_wr = 1'b1;
    query_valid = 1'b1;
    @(negedge clk);
    check("R2 first of pair", outs(), 6'b110001);
    policy = 2'd0;
    @(negedge clk);
    check("R2 second of pair", outs(), 6'b110100);
    query_valid = 1'b0;
    @(negedge clk);
    check("R2 drop", outs(), 6'b000000);

    // R10: reset mid-stream clears outputs
    query_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears", outs(), 6'b000000);
    query_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule